// File: doc/BRIEF.md
# PCI Host Configuration Access Port

This block is the host-facing side of a PCI host bridge's configuration mechanism. Software sees a small control region. A configuration address register sits at byte offset 0x0 and a configuration data window at offset 0x4. A local register bank starts at 0x80000. The bank holds the bridge's own 64-byte configuration header and a status word.

Writes to the address register are repaired instead of trusted. Only a full-word store at offset 0 lands. Bits 1:0 are cleared and the enable bit 31 is forced on, so software that leaves the enable bit clear or sets stray low bits still produces a usable address. An access to the data window becomes one request on a configuration-cycle interface. The request carries the bus, device, function and dword fields decoded from the stored address, together with the host byte lanes. The request is held until the far side acknowledges it. A read from a device that does not exist completes with all ones.

Top module: `cfgp_port`

## Requirements
- R1: An accepted write with `host_be` = 4'b1111 at byte address 0x0 stores `(host_wdata & 32'hFFFF_FFFC) | 32'h8000_0000` in the address register. The new value is visible from the next cycle.
- R2: A write to address 0x0 with any other `host_be` value leaves the address register unchanged. So does a write to a misaligned address (0x1 to 0x3).
- R3: A read of address 0x0 returns the stored address unchanged. After reset the stored address is 0, `host_ready` is 1 and `cfg_req` is 0.
- R4: An accepted access to address 0x4 raises `cfg_req` on the next cycle and holds it until `cfg_ack`. The fields come from the stored address: `cfg_bus` from bits 23:16, `cfg_dev` from 15:11, `cfg_fn` from 10:8 and `cfg_dword` from 7:2. `cfg_be`, `cfg_wdata` and `cfg_write` carry the host access. `host_ready` is 0 while `cfg_req` is 1.
- R5: A configuration read completes with `host_rvalid` = 1 in the cycle after the one in which `cfg_ack` is sampled. `host_rdata` then equals `cfg_rdata`.
- R6: A configuration read acknowledged with `cfg_nodev` = 1 returns 32'hFFFF_FFFF.
- R7: Bank offsets 0x00 to 0x3F (addresses 0x80000 to 0x8003F) are read/write header storage. Byte lane i (`host_be[i]`, data bits 8i+7:8i) holds the byte at word offset + i, which is little-endian order. Each lane is written only when its enable is set.
- R8: The status word at address 0x800E0 is read/write per byte lane and resets to 0.
- R9: A read of any other address in the control region returns 0, and a write to one has no effect on any stored value.
- R10: A read of any address other than 0x4 returns `host_rvalid` = 1 exactly one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Byte address in the control region |
| host_be | input | 4 | Byte lane enables |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Access accepted when high with host_valid |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 32 | Read data |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_write | output | 1 | Configuration request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dword | output | 6 | Target dword register index |
| cfg_be | output | 4 | Byte lanes of the request |
| cfg_wdata | output | 32 | Write data of the request |
| cfg_ack | input | 1 | Request completed |
| cfg_nodev | input | 1 | Completed with no device present |
| cfg_rdata | input | 32 | Read data of a completed request |

## Verification
A corrupted address register appears on the decoded `cfg_bus`/`cfg_dev`/`cfg_fn`/`cfg_dword` outputs of the very next configuration request, and on the next read of offset 0 one cycle after it is issued. A stuck busy state shows immediately as `host_ready` staying low and `cfg_req` staying high after an acknowledge. A misrouted byte lane in the header or status storage shows on the first read-back of that word. The bench therefore follows each write with a read-back or a data-window request.

// File: rtl/cfgp_pkg.sv
// Package: shared types and helpers for the configuration access port.
// Assumes a 32-bit host data path with four byte lanes.
package cfgp_pkg;

    // Which target a host access selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_BANK = 2'd3
    } cfgp_sel_e;

    // Decoded target of a configuration request.
    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] dword;
    } cfgp_target_t;

    // Repair a software-written address: clear bits 1:0, force the enable bit.
    function automatic logic [31:0] cfgp_fix_addr(input logic [31:0] v);
        return (v & 32'hFFFF_FFFC) | 32'h8000_0000;
    endfunction

endpackage

// File: rtl/cfgp_addr_reg.sv
// Module: configuration address register.
// Holds the repaired address and splits it into target fields.
// Assumes wr_en is a single-cycle strobe for an accepted write to offset 0.
module cfgp_addr_reg
    import cfgp_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   be,
    input  logic [31:0]  wdata,
    output logic [31:0]  addr_q,
    output cfgp_target_t target
);

    // Store full-word writes only, repaired; drop partial ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_en && (be == 4'hF)) begin
            addr_q <= cfgp_fix_addr(wdata);
        end
    end

    // Split the stored address into bus/device/function/dword fields.
    always_comb begin
        target.bus   = addr_q[23:16];
        target.dev   = addr_q[15:11];
        target.fn    = addr_q[10:8];
        target.dword = addr_q[7:2];
    end

endmodule

// File: rtl/cfgp_local_bank.sv
// Module: local register bank holding the bridge's own header and a status word.
// Header bytes are kept in byte order; lane i of a word maps to offset+i.
// Assumes dword-aligned offsets; the read word is combinational.
module cfgp_local_bank #(
    parameter int          HDR_BYTES = 64,
    parameter int          OFF_W     = 8,
    parameter logic [7:0]  STS_OFF   = 8'hE0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd_word
);

    localparam int               HIDX_W  = $clog2(HDR_BYTES);
    localparam logic [OFF_W-1:0] HDR_LIM = OFF_W'(HDR_BYTES);
    localparam logic [OFF_W-1:0] STS_AT  = OFF_W'(STS_OFF);

    logic [7:0]  hdr [HDR_BYTES];
    logic [31:0] sts_q;
    logic        hdr_hit;
    logic        sts_hit;

    // Classify the offset.
    always_comb begin
        hdr_hit = (off < HDR_LIM);
        sts_hit = (off == STS_AT);
    end

    // One storage byte per header offset, written from its own lane.
    for (genvar b = 0; b < HDR_BYTES; b++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hdr[b] <= '0;
            end else if (wr_en && hdr_hit && be[b % 4] &&
                         (off[HIDX_W-1:2] == (HIDX_W-2)'(b / 4))) begin
                hdr[b] <= wdata[8*(b%4) +: 8];
            end
        end
    end

    // Status word, one lane at a time.
    for (genvar l = 0; l < 4; l++) begin : g_sts
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[8*l +: 8] <= '0;
            end else if (wr_en && sts_hit && be[l]) begin
                sts_q[8*l +: 8] <= wdata[8*l +: 8];
            end
        end
    end

    // Assemble the read word; unimplemented offsets read zero.
    always_comb begin
        rd_word = '0;
        if (hdr_hit) begin
            for (int l = 0; l < 4; l++) begin
                rd_word[8*l +: 8] = hdr[{off[HIDX_W-1:2], 2'(l)}];
            end
        end else if (sts_hit) begin
            rd_word = sts_q;
        end
    end

endmodule

// File: rtl/cfgp_cycle_ctl.sv
// Module: configuration request sequencer for the data window.
// Raises a request the cycle after start, holds it until ack, then returns
// read data (all ones when no device answered).
// Assumes start is only pulsed while busy is low.
module cfgp_cycle_ctl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        write,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic        ack,
    input  logic        nodev,
    input  logic [31:0] ack_rdata,
    output logic        busy,
    output logic        req_write,
    output logic [3:0]  req_be,
    output logic [31:0] req_wdata,
    output logic        rvalid,
    output logic [31:0] rdata
);

    // Track the outstanding request and latch its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            req_write <= 1'b0;
            req_be    <= '0;
            req_wdata <= '0;
        end else if (start && !busy) begin
            busy      <= 1'b1;
            req_write <= write;
            req_be    <= be;
            req_wdata <= wdata;
        end else if (busy && ack) begin
            busy      <= 1'b0;
        end
    end

    // Return read data one cycle after the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= busy && ack && !req_write;
            if (busy && ack && !req_write) begin
                rdata <= nodev ? 32'hFFFF_FFFF : ack_rdata;
            end
        end
    end

endmodule

// File: rtl/cfgp_port.sv
// Module: top of the host configuration access port.
// Decodes the control region (address register, data window, local bank),
// answers local reads one cycle after acceptance and routes data-window
// accesses to the configuration-cycle interface.
// Assumes the host holds no second access while host_ready is low.
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BANK_BASE = 20'h80000,
    parameter int                HDR_BYTES = 64,
    parameter logic [7:0]        STS_OFF   = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [3:0]        host_be,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [31:0]       host_rdata,
    output logic              cfg_req,
    output logic              cfg_write,
    output logic [7:0]        cfg_bus,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_fn,
    output logic [5:0]        cfg_dword,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic              cfg_nodev,
    input  logic [31:0]       cfg_rdata
);

    localparam int                SPAN_W    = 8;
    localparam logic [ADDR_W-1:0] ADDR_PORT = '0;
    localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(4);

    cfgp_sel_e    sel;
    logic         acc;
    logic [31:0]  addr_q;
    cfgp_target_t target;
    logic [31:0]  bank_rd;
    logic         busy;
    logic         cyc_rvalid;
    logic [31:0]  cyc_rdata;
    logic         loc_rvalid;
    logic [31:0]  loc_rdata;

    // Accept a host access whenever no request is outstanding.
    always_comb begin
        host_ready = !busy;
        acc        = host_valid && host_ready;
    end

    // Decode the target of the access; misaligned addresses hit nothing.
    always_comb begin
        sel = SEL_NONE;
        if (host_addr[1:0] == 2'b00) begin
            if (host_addr == ADDR_PORT) begin
                sel = SEL_ADDR;
            end else if (host_addr == DATA_PORT) begin
                sel = SEL_DATA;
            end else if (host_addr[ADDR_W-1:SPAN_W] == BANK_BASE[ADDR_W-1:SPAN_W]) begin
                sel = SEL_BANK;
            end
        end
    end

    cfgp_addr_reg u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (acc && host_write && (sel == SEL_ADDR)),
        .be     (host_be),
        .wdata  (host_wdata),
        .addr_q (addr_q),
        .target (target)
    );

    cfgp_local_bank #(
        .HDR_BYTES (HDR_BYTES),
        .OFF_W     (SPAN_W),
        .STS_OFF   (STS_OFF)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc && host_write && (sel == SEL_BANK)),
        .off     (host_addr[SPAN_W-1:0]),
        .be      (host_be),
        .wdata   (host_wdata),
        .rd_word (bank_rd)
    );

    cfgp_cycle_ctl u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (acc && (sel == SEL_DATA)),
        .write     (host_write),
        .be        (host_be),
        .wdata     (host_wdata),
        .ack       (cfg_ack),
        .nodev     (cfg_nodev),
        .ack_rdata (cfg_rdata),
        .busy      (busy),
        .req_write (cfg_write),
        .req_be    (cfg_be),
        .req_wdata (cfg_wdata),
        .rvalid    (cyc_rvalid),
        .rdata     (cyc_rdata)
    );

    // Register the local read result one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_rvalid <= 1'b0;
            loc_rdata  <= '0;
        end else begin
            loc_rvalid <= acc && !host_write && (sel != SEL_DATA);
            if (acc && !host_write && (sel != SEL_DATA)) begin
                case (sel)
                    SEL_ADDR: loc_rdata <= addr_q;
                    SEL_BANK: loc_rdata <= bank_rd;
                    default:  loc_rdata <= '0;
                endcase
            end
        end
    end

    // Merge the two response sources and expose the request fields.
    always_comb begin
        host_rvalid = loc_rvalid || cyc_rvalid;
        host_rdata  = cyc_rvalid ? cyc_rdata : loc_rdata;
        cfg_req     = busy;
        cfg_bus     = target.bus;
        cfg_dev     = target.dev;
        cfg_fn      = target.fn;
        cfg_dword   = target.dword;
    end

endmodule

// File: rtl/cfgp_port_chk.sv
// Module: assertion checker for cfgp_port, attached by bind.
// Observes ports plus the stored address register.
module cfgp_port_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_ready,
    input logic              host_write,
    input logic [ADDR_W-1:0] host_addr,
    input logic [3:0]        host_be,
    input logic [31:0]       host_wdata,
    input logic              host_rvalid,
    input logic [31:0]       host_rdata,
    input logic              cfg_req,
    input logic              cfg_ack,
    input logic              cfg_write,
    input logic              cfg_nodev,
    input logic [7:0]        cfg_bus,
    input logic [4:0]        cfg_dev,
    input logic [2:0]        cfg_fn,
    input logic [5:0]        cfg_dword,
    input logic [31:0]       addr_q
);

    logic acc;
    always_comb acc = host_valid && host_ready;

    assert_addr_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && host_write && (host_addr == '0) && (host_be == 4'hF)
        |=> addr_q == (($past(host_wdata) & 32'hFFFF_FFFC) | 32'h8000_0000));

    assert_partial_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && host_write && (host_addr == '0) && (host_be != 4'hF)
        |=> $stable(addr_q));

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack
        |=> cfg_req && $stable(cfg_bus) && $stable(cfg_dev) && $stable(cfg_fn)
            && $stable(cfg_dword) && $stable(cfg_write));

    assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !host_ready);

    assert_rd_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_ack && !cfg_write |=> host_rvalid);

    assert_nodev_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_ack && !cfg_write && cfg_nodev
        |=> host_rdata == 32'hFFFF_FFFF);

    assert_local_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !host_write && (host_addr != ADDR_W'(4)) |=> host_rvalid);

endmodule

bind cfgp_port cfgp_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .host_write  (host_write),
    .host_addr   (host_addr),
    .host_be     (host_be),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .cfg_req     (cfg_req),
    .cfg_ack     (cfg_ack),
    .cfg_write   (cfg_write),
    .cfg_nodev   (cfg_nodev),
    .cfg_bus     (cfg_bus),
    .cfg_dev     (cfg_dev),
    .cfg_fn      (cfg_fn),
    .cfg_dword   (cfg_dword),
    .addr_q      (addr_q)
);

// File: tb/sim_cfgp_port.sv
// Bench: scoreboard-driven test of cfgp_port with a configuration responder.
module sim_cfgp_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [19:0] host_addr = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic        host_rvalid;
    logic [31:0] host_rdata;
    logic        cfg_req;
    logic        cfg_write;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [5:0]  cfg_dword;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic        cfg_nodev = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // Responder expectations.
    logic [7:0]  e_bus;
    logic [4:0]  e_dev;
    logic [2:0]  e_fn;
    logic [5:0]  e_dword;
    logic        e_wr;
    logic [3:0]  e_be;
    logic [31:0] e_wd;
    int          r_lat = 2;
    logic [31:0] r_data = '0;
    logic        r_nodev = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cfgp_port u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item per read response.
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected response", host_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                chk(host_rdata == e, t, host_rdata, e);
            end
        end
    end

    // Responder for the configuration-cycle interface.
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_req) begin
                chk(cfg_bus == e_bus, "R4 bus", 32'(cfg_bus), 32'(e_bus));
                chk(cfg_dev == e_dev, "R4 dev", 32'(cfg_dev), 32'(e_dev));
                chk(cfg_fn == e_fn, "R4 fn", 32'(cfg_fn), 32'(e_fn));
                chk(cfg_dword == e_dword, "R4 dword", 32'(cfg_dword), 32'(e_dword));
                chk(cfg_write == e_wr, "R4 write flag", 32'(cfg_write), 32'(e_wr));
                chk(cfg_be == e_be, "R4 lanes", 32'(cfg_be), 32'(e_be));
                if (e_wr) chk(cfg_wdata == e_wd, "R4 wdata", cfg_wdata, e_wd);
                chk(!host_ready, "R4 stall", 32'(host_ready), 32'h0);
                repeat (r_lat) @(negedge clk);
                chk(cfg_req, "R4 held", 32'(cfg_req), 32'h1);
                cfg_ack   = 1'b1;
                cfg_rdata = r_data;
                cfg_nodev = r_nodev;
                @(negedge clk);
                cfg_ack   = 1'b0;
                cfg_nodev = 1'b0;
            end
        end
    end

    // Driver: one-cycle write pulse.
    task automatic do_wr(input logic [19:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_be = be; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    // Driver: local read; pushes the expected value and checks the latency.
    task automatic do_rd(input logic [19:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a; host_be = 4'hF;
        @(negedge clk);
        host_valid = 1'b0;
        chk(host_rvalid, "R10 latency", 32'(host_rvalid), 32'h1);
    endtask

    // Driver: data-window access; waits until the port is ready again.
    task automatic do_cfg(input bit wr, input logic [3:0] be, input logic [31:0] d,
                          input logic [31:0] e, input string t);
        e_wr = wr; e_be = be; e_wd = d;
        if (!wr) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = 20'h4; host_be = be; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
        while (!host_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_target(input logic [7:0] b, input logic [4:0] dv,
                              input logic [2:0] f, input logic [5:0] r);
        e_bus = b; e_dev = dv; e_fn = f; e_dword = r;
        do_wr(20'h0, 4'hF, {8'h00, b, dv, f, r, 2'b11});
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        chk(host_ready, "R3 reset ready", 32'(host_ready), 32'h1);
        chk(!cfg_req, "R3 reset req", 32'(cfg_req), 32'h0);
        do_rd(20'h0, 32'h0, "R3 reset address");
        do_rd(20'h800E0, 32'h0, "R8 status reset");

        // R1 repair of written address
        do_wr(20'h0, 4'hF, 32'h00AB_CD07);
        do_rd(20'h0, 32'h80AB_CD04, "R1 enable forced, low bits cleared");
        do_wr(20'h0, 4'hF, 32'h1234_5673);
        do_rd(20'h0, 32'h9234_5670, "R1 second pattern");

        // R2 partial / misaligned writes dropped
        do_wr(20'h0, 4'b0011, 32'hFFFF_FFFF);
        do_rd(20'h0, 32'h9234_5670, "R2 partial write ignored");
        do_wr(20'h2, 4'hF, 32'h0000_0000);
        do_rd(20'h0, 32'h9234_5670, "R2 misaligned write ignored");

        // R4/R5 configuration read
        set_target(8'h5A, 5'h13, 3'd5, 6'h2C);
        do_rd(20'h0, 32'h805A_9DB0, "R3 address readback");
        r_lat = 3; r_data = 32'hCAFE_F00D; r_nodev = 1'b0;
        do_cfg(1'b0, 4'hF, 32'h0, 32'hCAFE_F00D, "R5 config read data");

        // R4 configuration write with partial lanes
        set_target(8'h01, 5'h1F, 3'd7, 6'h3F);
        r_lat = 0;
        do_cfg(1'b1, 4'b0110, 32'h1122_3344, 32'h0, "R4 config write");

        // R6 no device
        set_target(8'hFF, 5'h00, 3'd0, 6'h00);
        r_lat = 1; r_data = 32'h0000_1234; r_nodev = 1'b1;
        do_cfg(1'b0, 4'hF, 32'h0, 32'hFFFF_FFFF, "R6 no device returns ones");
        r_nodev = 1'b0;

        // R7 header little-endian lanes
        do_wr(20'h80004, 4'hF, 32'h4433_2211);
        do_wr(20'h80004, 4'b0010, 32'h0000_AA00);
        do_rd(20'h80004, 32'h4433_AA11, "R7 lane 1 write");
        do_wr(20'h8003C, 4'b1000, 32'h5500_0000);
        do_rd(20'h8003C, 32'h5500_0000, "R7 last header word lane 3");
        do_rd(20'h80000, 32'h0, "R7 neighbour untouched");

        // R9 unimplemented offsets
        do_wr(20'h80040, 4'hF, 32'hFFFF_FFFF);
        do_rd(20'h80040, 32'h0, "R9 unimplemented reads zero");
        do_rd(20'h8003C, 32'h5500_0000, "R9 write had no effect");
        do_wr(20'h00008, 4'hF, 32'hFFFF_FFFF);
        do_rd(20'h00008, 32'h0, "R9 outside bank reads zero");
        do_rd(20'h800E0, 32'h0, "R9 status untouched");

        // R8 status register
        do_wr(20'h800E0, 4'hF, 32'hDEAD_BEEF);
        do_rd(20'h800E0, 32'hDEAD_BEEF, "R8 status full write");
        do_wr(20'h800E0, 4'b0001, 32'h0000_0012);
        do_rd(20'h800E0, 32'hDEAD_BE12, "R8 status lane 0");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule